// File: doc/BRIEF.md
# Programmable Feedback Divider

This block divides a fast input clock by a programmable ratio N. It is meant for the feedback path of a phase-locked frequency synthesizer. Every N input clocks it produces one period. Each period is marked by a terminal pulse one input clock wide. A second output is high for the first half of the period and low for the rest, which gives a near-square wave that a slow phase detector can follow.

The ratio can come from either of two settings, chosen by a mode input:

- **Binary setting:** a 10-bit word is expanded to an 11-bit ratio by driving two adjacent ratio bits from one setting bit. This reaches 0–255, 768–1279 and 1792–2047.
- **Decimal setting:** four BCD digits give ratios from 1 to 3999.

Either word can be taken with inverted polarity. This suits switch banks that pull unconnected lines high.

The ratio in force is reloaded only at a period boundary, so a new setting never shortens the period in progress. The terminal count is decoded one clock early and registered, so each period is exactly N clocks with no reset overrun. Ratios that cannot divide (0 or 1) and malformed decimal settings raise an error flag.

Top module: `prog_divider`

## Requirements
- R1: Once running with a ratio N of 2 or more, `tc_pulse` is high exactly once every N clocks. The distance between consecutive pulses is exactly N.
- R2: For N of 2 or more, `tc_pulse` is high for exactly one clock per period.
- R3: For N of 2 or more, `sq_out` is high for floor(N/2) clocks and low for the remaining clocks of each period. It is high in the clock where `tc_pulse` is high.
- R4: In binary mode (`use_bcd`=0), the ratio is formed as follows: bit 10 = setting bit 9, bits 9 and 8 = setting bit 8, bits 7..0 = setting bits 7..0. So 0x180 gives 896, 0x237 gives 1079 and 0x2FF gives 1279.
- R5: In decimal mode (`use_bcd`=1), `bcd_set[15:12]` holds the thousands digit, `[11:8]` the hundreds, `[7:4]` the tens and `[3:0]` the units. The ratio is their decimal value, up to 3999.
- R6: A decimal setting with any digit above 9, or a thousands digit above 3, sets `ratio_err` and holds both outputs low.
- R7: With `active_low`=1, the selected setting word is inverted bit by bit before it is decoded.
- R8: A ratio of 0 holds both outputs low. A ratio of 1 holds `tc_pulse` high every clock and `sq_out` low.
- R9: `ratio_err` is 1 exactly when the ratio in force is below 2 or came from a malformed decimal setting. It is 0 for every valid ratio of 2 or more.
- R10: A new setting is taken only at the end of the current period. The period in progress completes with the old ratio.
- R11: The synchronous reset drives `tc_pulse`, `sq_out` and `ratio_err` low. The first clock edge after release starts a period, so `tc_pulse` is high in the clock after that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock to be divided |
| rst | input | 1 | Synchronous reset, active high |
| use_bcd | input | 1 | 0 selects the binary setting, 1 selects the decimal setting |
| active_low | input | 1 | 1 inverts the selected setting word before decoding |
| bin_set | input | 10 | Binary setting word |
| bcd_set | input | 16 | Four-digit BCD setting word |
| tc_pulse | output | 1 | One-clock pulse at the start of each divided period |
| sq_out | output | 1 | Near-square divided output |
| ratio_err | output | 1 | The ratio in force is below 2 or malformed |

## Verification
Directed runs use the ratios 2, 3, 896, 1079 and 1279 in both modes, plus 3999 and 2047 at the tops of the two ranges. These runs separate the odd/even half-period split and the two bit-tying cases of the binary expansion. The same ratios given with inverted polarity must produce identical periods, which shows that the inversion happens before decoding. A setting changed three clocks into a period of 10 must give one more 7-clock gap before the new period length appears; this catches a reload that is too early. Seeded random settings in both modes and both polarities, plus the ratios 0 and 1 and two kinds of malformed digits, exercise the error flag and the quiet and pass-through behaviour.

// File: rtl/pdiv_pkg.sv
package pdiv_pkg;

   typedef enum logic {
      SRC_BINARY  = 1'b0,
      SRC_DECIMAL = 1'b1
   } src_e;

   localparam int DEC_RADIX  = 10;
   localparam int NIBBLE_W   = 4;
   localparam int MIN_DIVIDE = 2;

endpackage

// File: rtl/pdiv_bin_expand.sv
module pdiv_bin_expand #(
   parameter int SET_W   = 10,
   parameter int TIE_POS = 8,
   parameter int CNT_W   = 12
) (
   input  logic [SET_W-1:0] set_i,
   output logic [CNT_W-1:0] ratio_o
);

   localparam int RATIO_W = SET_W + 1;

   if (TIE_POS >= SET_W) begin : g_bad_tie
      $error("TIE_POS must index a bit of the setting word");
   end
   if (CNT_W < RATIO_W) begin : g_bad_width
      $error("CNT_W too small for the expanded binary ratio");
   end

   // Bits at or below the tie position map straight across; the bit above
   // the tie repeats the tied setting bit; higher bits shift down by one.
   for (genvar k = 0; k < CNT_W; k++) begin : g_map
      if (k <= TIE_POS) begin : g_low
         assign ratio_o[k] = set_i[k];
      end else if (k < RATIO_W) begin : g_high
         assign ratio_o[k] = set_i[k-1];
      end else begin : g_pad
         assign ratio_o[k] = 1'b0;
      end
   end

endmodule

// File: rtl/pdiv_bcd_to_bin.sv
module pdiv_bcd_to_bin
   import pdiv_pkg::*;
#(
   parameter int DIGITS  = 4,
   parameter int TOP_MAX = 3,
   parameter int CNT_W   = 12
) (
   input  logic [NIBBLE_W*DIGITS-1:0] bcd_i,
   output logic [CNT_W-1:0]           ratio_o,
   output logic                       bad_o
);

   localparam int LSD_WEIGHT = DEC_RADIX ** (DIGITS - 1);
   localparam int DEC_MAX    = TOP_MAX * LSD_WEIGHT + LSD_WEIGHT - 1;

   if (DIGITS < 1) begin : g_bad_digits
      $error("DIGITS must be at least 1");
   end
   if (TOP_MAX > 9 || TOP_MAX < 0) begin : g_bad_top
      $error("TOP_MAX must be a decimal digit");
   end
   if (DEC_MAX >= 2 ** CNT_W) begin : g_bad_width
      $error("CNT_W too small for the largest decimal ratio");
   end

   logic [CNT_W-1:0] acc;
   logic             bad;

   // Horner evaluation, most significant digit first.
   always_comb begin
      logic [NIBBLE_W-1:0] dig;
      acc = '0;
      bad = 1'b0;
      for (int d = DIGITS - 1; d >= 0; d--) begin
         dig = bcd_i[NIBBLE_W*d +: NIBBLE_W];
         if (dig > 4'd9) bad = 1'b1;
         if (d == DIGITS - 1 && dig > NIBBLE_W'(TOP_MAX)) bad = 1'b1;
         acc = CNT_W'(acc * CNT_W'(DEC_RADIX)) + CNT_W'(dig);
      end
   end

   assign ratio_o = bad ? '0 : acc;
   assign bad_o   = bad;

endmodule

// File: rtl/pdiv_core.sv
module pdiv_core #(
   parameter int CNT_W = 12
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [CNT_W-1:0] ratio_i,
   input  logic             err_i,
   output logic             tc_o,
   output logic             sq_o,
   output logic             err_o
);

   if (CNT_W < 2) begin : g_bad_width
      $error("CNT_W must be at least 2");
   end

   logic [CNT_W-1:0] cnt_q, n_q;
   logic [CNT_W-1:0] cnt_nxt, n_nxt, half_nxt;
   logic             err_q, err_nxt;
   logic             tc_q, sq_q;
   logic             wrap;

   // Terminal count decoded at N-1 so the restart costs no extra clock.
   assign wrap     = (n_q < CNT_W'(2)) || (cnt_q == n_q - 1'b1);
   assign n_nxt    = wrap ? ratio_i : n_q;
   assign err_nxt  = wrap ? err_i : err_q;
   assign cnt_nxt  = wrap ? '0 : cnt_q + 1'b1;
   assign half_nxt = n_nxt >> 1;

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt_q <= '0;
         n_q   <= '0;
         err_q <= 1'b0;
         tc_q  <= 1'b0;
         sq_q  <= 1'b0;
      end else begin
         cnt_q <= cnt_nxt;
         n_q   <= n_nxt;
         err_q <= err_nxt;
         tc_q  <= (cnt_nxt == '0) && (n_nxt != '0);
         sq_q  <= cnt_nxt < half_nxt;
      end
   end

   assign tc_o  = tc_q;
   assign sq_o  = sq_q;
   assign err_o = err_q;

   p_cnt_in_range_r1: assert property (@(posedge clk) disable iff (rst)
      (n_q >= CNT_W'(2)) |-> (cnt_q < n_q));

   p_tc_one_wide_r2: assert property (@(posedge clk) disable iff (rst)
      (tc_q && n_q >= CNT_W'(2)) |=> !tc_q);

   p_zero_quiet_r8: assert property (@(posedge clk) disable iff (rst)
      (n_q == '0) |-> (!tc_q && !sq_q));

   p_one_passes_r8: assert property (@(posedge clk) disable iff (rst)
      (n_q == CNT_W'(1)) |-> (tc_q && !sq_q));

   p_ratio_held_r10: assert property (@(posedge clk) disable iff (rst)
      !wrap |=> $stable(n_q));

   p_sq_starts_high_r3: assert property (@(posedge clk) disable iff (rst)
      (tc_q && n_q >= CNT_W'(2)) |-> sq_q);

endmodule

// File: rtl/prog_divider.sv
module prog_divider
   import pdiv_pkg::*;
#(
   parameter int BIN_SET_W   = 10,
   parameter int TIE_POS     = 8,
   parameter int BCD_DIGITS  = 4,
   parameter int BCD_TOP_MAX = 3,
   parameter int CNT_W       = 12
) (
   input  logic                       clk,
   input  logic                       rst,
   input  logic                       use_bcd,
   input  logic                       active_low,
   input  logic [BIN_SET_W-1:0]       bin_set,
   input  logic [NIBBLE_W*BCD_DIGITS-1:0] bcd_set,
   output logic                       tc_pulse,
   output logic                       sq_out,
   output logic                       ratio_err
);

   localparam int BCD_W = NIBBLE_W * BCD_DIGITS;

   logic [BIN_SET_W-1:0] bin_word;
   logic [BCD_W-1:0]     bcd_word;
   logic [CNT_W-1:0]     bin_ratio, dec_ratio, ratio_sel;
   logic                 dec_bad, err_sel;
   src_e                 src;

   assign bin_word = active_low ? ~bin_set : bin_set;
   assign bcd_word = active_low ? ~bcd_set : bcd_set;
   assign src      = src_e'(use_bcd);

   pdiv_bin_expand #(
      .SET_W   (BIN_SET_W),
      .TIE_POS (TIE_POS),
      .CNT_W   (CNT_W)
   ) i_bin (
      .set_i   (bin_word),
      .ratio_o (bin_ratio)
   );

   pdiv_bcd_to_bin #(
      .DIGITS  (BCD_DIGITS),
      .TOP_MAX (BCD_TOP_MAX),
      .CNT_W   (CNT_W)
   ) i_dec (
      .bcd_i   (bcd_word),
      .ratio_o (dec_ratio),
      .bad_o   (dec_bad)
   );

   assign ratio_sel = (src == SRC_DECIMAL) ? dec_ratio : bin_ratio;
   assign err_sel   = ((src == SRC_DECIMAL) && dec_bad) ||
                      (ratio_sel < CNT_W'(MIN_DIVIDE));

   pdiv_core #(
      .CNT_W   (CNT_W)
   ) i_core (
      .clk     (clk),
      .rst     (rst),
      .ratio_i (ratio_sel),
      .err_i   (err_sel),
      .tc_o    (tc_pulse),
      .sq_o    (sq_out),
      .err_o   (ratio_err)
   );

   p_err_matches_quiet_r9: assert property (@(posedge clk) disable iff (rst)
      (ratio_err && !tc_pulse) |-> !sq_out);

endmodule

// File: tb/test_prog_divider.sv
`timescale 1ns/1ps
module test_prog_divider;

   logic        clk = 1'b0;
   logic        rst;
   logic        use_bcd;
   logic        active_low;
   logic [9:0]  bin_set;
   logic [15:0] bcd_set;
   logic        tc_pulse, sq_out, ratio_err;

   int n_checks = 0;
   int n_err    = 0;
   int last_n   = 2;
   int cycles   = 0;
   bit done     = 1'b0;

   always #4 clk = ~clk;

   prog_divider i_prog_divider (
      .clk        (clk),
      .rst        (rst),
      .use_bcd    (use_bcd),
      .active_low (active_low),
      .bin_set    (bin_set),
      .bcd_set    (bcd_set),
      .tc_pulse   (tc_pulse),
      .sq_out     (sq_out),
      .ratio_err  (ratio_err)
   );

   function automatic int bin_n(int s);
      return ((s >> 9) & 1) * 1024 + ((s >> 8) & 1) * 768 + (s & 255);
   endfunction

   function automatic int bcd_n(int w);
      return ((w >> 12) & 15) * 1000 + ((w >> 8) & 15) * 100 +
             ((w >> 4) & 15) * 10 + (w & 15);
   endfunction

   task automatic check_eq(string req, string what, int act, int exp);
      n_checks++;
      if (act != exp) begin
         n_err++;
         $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic apply(bit bcd, bit al, int binw, int bcdw);
      use_bcd    = bcd;
      active_low = al;
      bin_set    = al ? ~10'(binw) : 10'(binw);
      bcd_set    = al ? ~16'(bcdw) : 16'(bcdw);
   endtask

   task automatic wait_tc(output bit ok);
      int k = 0;
      @(negedge clk);
      while (!tc_pulse && k < 6000) begin
         @(negedge clk);
         k++;
      end
      ok = tc_pulse;
   endtask

   // Syncs to a period start, then checks one full period of length n.
   task automatic measure(string req, int n);
      bit ok;
      int tcn = 0;
      int hi  = 0;
      int sq0;
      wait_tc(ok);
      check_eq(req, "R1 period start seen", int'(ok), 1);
      sq0 = sq_out;
      for (int i = 0; i < n; i++) begin
         tcn += tc_pulse;
         hi  += sq_out;
         @(negedge clk);
      end
      check_eq(req, "R1 pulse after N clocks", int'(tc_pulse), 1);
      check_eq(req, "R2 pulses within one period", tcn, 1);
      check_eq(req, "R3 square high clocks", hi, n / 2);
      check_eq(req, "R3 square high at period start", sq0, 1);
      check_eq(req, "R9 flag for valid ratio", int'(ratio_err), 0);
      last_n = n;
   endtask

   task automatic observe_fixed(string req, int tc_exp);
      int tcn = 0;
      int sqn = 0;
      repeat (last_n + 3) @(negedge clk);
      for (int i = 0; i < 16; i++) begin
         tcn += tc_pulse;
         sqn += sq_out;
         @(negedge clk);
      end
      check_eq(req, "pulse clocks in 16", tcn, 16 * tc_exp);
      check_eq(req, "square clocks in 16", sqn, 0);
      check_eq(req, "R9 error flag", int'(ratio_err), 1);
      last_n = 1;
   endtask

   initial begin
      forever begin
         @(posedge clk);
         cycles++;
         if (cycles >= 190000 && !done) begin
            n_checks++;
            n_err++;
            $display("FAIL R1 watchdog: got %0d cycles expected fewer", cycles);
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
            $finish;
         end
      end
   end

   initial begin
      int bin_words [5] = '{10'h002, 10'h003, 10'h180, 10'h237, 10'h2FF};
      int bcd_words [5] = '{16'h0002, 16'h0003, 16'h0896, 16'h1079, 16'h1279};
      int ratios    [5] = '{2, 3, 896, 1079, 1279};
      int k;
      void'($urandom(32'd7331));

      rst = 1'b1;
      apply(1'b0, 1'b0, 10'h002, 16'h0000);
      repeat (3) @(negedge clk);
      check_eq("R11", "pulse in reset", int'(tc_pulse), 0);
      check_eq("R11", "square in reset", int'(sq_out), 0);
      check_eq("R11", "flag in reset", int'(ratio_err), 0);
      rst = 1'b0;
      @(negedge clk);
      check_eq("R11", "pulse after first edge", int'(tc_pulse), 1);

      // R4: binary ratios; the mapping is checked against bin_n
      for (int i = 0; i < 5; i++) begin
         check_eq("R4", "bench expansion", bin_n(bin_words[i]), ratios[i]);
         apply(1'b0, 1'b0, bin_words[i], 16'h0000);
         measure("R4", ratios[i]);
      end
      apply(1'b0, 1'b0, 10'h3FF, 16'h0000);
      measure("R4", bin_n(10'h3FF));

      // R5: decimal ratios
      for (int i = 0; i < 5; i++) begin
         check_eq("R5", "bench decimal", bcd_n(bcd_words[i]), ratios[i]);
         apply(1'b1, 1'b0, 10'h000, bcd_words[i]);
         measure("R5", ratios[i]);
      end
      apply(1'b1, 1'b0, 10'h000, 16'h3999);
      measure("R5", 3999);

      // R7: inverted polarity
      apply(1'b0, 1'b1, 10'h237, 16'h0000);
      measure("R7", 1079);
      apply(1'b1, 1'b1, 10'h000, 16'h0896);
      measure("R7", 896);
      apply(1'b1, 1'b1, 10'h000, 16'h0003);
      measure("R7", 3);

      // R10: change three clocks into a period of 10
      apply(1'b0, 1'b0, 10'h00A, 16'h0000);
      measure("R10", 10);
      repeat (3) @(negedge clk);
      apply(1'b0, 1'b0, 10'h006, 16'h0000);
      k = 0;
      do begin
         @(negedge clk);
         k++;
      end while (!tc_pulse && k < 50);
      check_eq("R10", "old period finishes", k, 7);
      measure("R10", 6);

      // R8: ratio 0 and ratio 1
      apply(1'b0, 1'b0, 10'h000, 16'h0000);
      observe_fixed("R8 ratio 0", 0);
      apply(1'b0, 1'b0, 10'h001, 16'h0000);
      observe_fixed("R8 ratio 1", 1);
      apply(1'b1, 1'b0, 10'h000, 16'h0001);
      observe_fixed("R8 decimal 1", 1);

      // R6: malformed decimal digits
      apply(1'b1, 1'b0, 10'h000, 16'h0A10);
      observe_fixed("R6 digit above 9", 0);
      apply(1'b1, 1'b0, 10'h000, 16'h4000);
      observe_fixed("R6 thousands above 3", 0);

      // recovery from error back to a valid ratio
      apply(1'b0, 1'b0, 10'h005, 16'h0000);
      measure("R9", 5);

      // R1: seeded random settings in both modes and polarities
      for (int i = 0; i < 8; i++) begin
         bit m  = 1'($urandom_range(0, 1));
         bit al = 1'($urandom_range(0, 1));
         int s, w, n;
         if (m) begin
            w = ($urandom_range(0, 1) << 12) | ($urandom_range(0, 9) << 8) |
                ($urandom_range(0, 9) << 4) | $urandom_range(0, 9);
            if (bcd_n(w) < 2) w = 16'h0002;
            n = bcd_n(w);
            apply(1'b1, al, 10'h000, w);
         end else begin
            s = $urandom_range(2, 1023);
            n = bin_n(s);
            apply(1'b0, al, s, 16'h0000);
         end
         measure("R1", n);
      end

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
      $finish;
   end

endmodule